// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Frame-Sync Generator

This block turns a fast system clock into the bit clock and frame sync of a time-division-multiplexed serial audio link. The bit rate comes from three dividers in series: a programmable modulus counter, an optional fixed divide-by-eight stage, and an optional divide-by-two stage. The bit clock is counted into slots (words) and slots into frames. A frame sync is placed at the head of each frame. Word-start and slot-index outputs tell a downstream shifter where each bit belongs.

Frame sync can last one bit or one whole slot. It can be inverted. It can also lead the frame by one bit. The configuration inputs are tracked while the block is disabled. While it runs, they are taken in only at the first bit of a frame, so a frame never mixes two settings. Every stream begins with a single lead-in bit that stands for the last bit of a frame. This gives the early frame sync a slot to occupy before the first real frame.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `tdm_clk_gen`

## Requirements
- R1: With the range bit and the divide-by-two bit both clear, `bclk` is a one-system-clock-wide high pulse. The pulses repeat every `psc_m1`+1 system clocks, where `psc_m1` is 0..255.
- R2: With the range bit set, the spacing between bit clocks is multiplied by 8.
- R3: With the divide-by-two bit set, `bclk` is a square wave. Its period is 2·(`psc_m1`+1)·(8 if range else 1) system clocks, and each high phase lasts exactly half of that period. A bit begins at each rising edge of `bclk`.
- R4: After the lead-in bit, each slot is `bits_m1`+1 bits long (1..32), and each frame has `slots_m1`+1 slots (1..32). `slot_idx` counts 0 up to `slots_m1` and then wraps. `word_start` is a one-system-clock pulse that coincides with the `bclk` rise of bit 0 of every slot.
- R5: The first bit after enable is a lead-in bit. During it, `slot_idx` equals `slots_m1` and `word_start` stays low. Slot 0, bit 0 follows on the next bit.
- R6: With `fs_word`=0, `fs_early`=0 and `fs_inv`=0, `fs` is high only during bit 0 of slot 0.
- R7: With `fs_word`=1, `fs` is active during every bit of slot 0.
- R8: With `fs_early`=1, the active window of `fs` moves one bit earlier. It then begins on the last bit of the previous frame, which for the first frame is the lead-in bit.
- R9: With `fs_inv`=1, the `fs` output is the complement of the level it would otherwise have, and that includes the idle level.
- R10: One clock after `en` is sampled low, `bclk` is 0, `word_start` is 0, `slot_idx` is 0, and `fs` equals `fs_inv`. Enabling the block again restarts the stream with a lead-in bit.
- R11: A change to the configuration inputs while the block is running has no effect until the first bit of the next frame. The frame in progress finishes with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears all counters |
| psc_m1 | input | 8 | Modulus divider ratio minus one |
| range_x8 | input | 1 | Insert the fixed divide-by-eight stage |
| half_rate | input | 1 | Insert the divide-by-two stage (square-wave bit clock) |
| slots_m1 | input | 5 | Slots per frame minus one |
| bits_m1 | input | 5 | Bits per slot minus one |
| fs_inv | input | 1 | Invert the frame sync |
| fs_word | input | 1 | Frame sync lasts one slot (else one bit) |
| fs_early | input | 1 | Frame sync leads the frame by one bit |
| bclk | output | 1 | Bit clock (pulse or square wave) |
| fs | output | 1 | Frame sync |
| word_start | output | 1 | Pulse on bit 0 of each slot |
| slot_idx | output | 5 | Index of the current slot |

## Verification
The assertions watch the following on every cycle: that frame sync and slot index change only at a bit boundary, that the slot index stays within the configured frame, that every word-start pulse lands on a high bit clock, that the outputs return to idle once the block is disabled, and that the active configuration stays frozen except at frame starts. Some behaviour can only be shown by the bench's scenarios, because it depends on how a whole run unfolds. This covers the exact bit-clock spacing and duty cycle for each divider combination, the placement of the frame sync window in its one-bit, one-slot, inverted and early forms, the lead-in bit, and a slot count changed in the middle of a frame that takes effect only at the next frame.

// File: rtl/tdm_clk_pkg.sv
package tdm_clk_pkg;
  localparam int PSC_W  = 8;
  localparam int SLOT_W = 5;
  localparam int WLEN_W = 5;
  localparam int X8_DIV = 8;
  localparam int X8_W   = $clog2(X8_DIV);

  typedef struct packed {
    logic [PSC_W-1:0] psc_m1;
    logic             range_x8;
    logic             half_rate;
  } tdm_div_t;

  typedef struct packed {
    logic [SLOT_W-1:0] slots_m1;
    logic [WLEN_W-1:0] bits_m1;
    logic              fs_word;
    logic              fs_early;
  } tdm_frm_t;

  typedef struct packed {
    tdm_div_t div;
    tdm_frm_t frm;
    logic     fs_inv;
  } tdm_cfg_t;

  typedef struct packed {
    logic [WLEN_W-1:0] bit_i;
    logic [SLOT_W-1:0] slot_i;
  } tdm_pos_t;

  // Advance one bit within the frame; >= keeps a stale count bounded.
  function automatic tdm_pos_t pos_step(tdm_pos_t p, tdm_frm_t c);
    tdm_pos_t r;
    r = p;
    if (p.bit_i >= c.bits_m1) begin
      r.bit_i  = '0;
      r.slot_i = (p.slot_i >= c.slots_m1) ? '0 : p.slot_i + 1'b1;
    end else begin
      r.bit_i = p.bit_i + 1'b1;
    end
    return r;
  endfunction

  // Frame sync window membership (uninverted, non-early view).
  function automatic logic fs_hit(tdm_pos_t p, tdm_frm_t c);
    return (p.slot_i == '0) && (c.fs_word || (p.bit_i == '0));
  endfunction
endpackage

// File: rtl/tdm_cfg_hold.sv
module tdm_cfg_hold
  import tdm_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  tdm_cfg_t cfg_in,
  output tdm_cfg_t cfg_act
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cfg_act <= '0;
    else if (load) cfg_act <= cfg_in;
  end
endmodule

// File: rtl/tdm_bit_divider.sv
module tdm_bit_divider
  import tdm_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  tdm_div_t div,
  output logic     bit_stb,
  output logic     bclk
);
  logic [PSC_W-1:0] mod_cnt;
  logic [X8_W-1:0]  x8_cnt;
  logic             half_q;
  logic             bclk_q;
  logic             mod_tick;
  logic             x8_last;
  logic             pre_tick;
  logic             half_nxt;

  assign mod_tick = en && (mod_cnt >= div.psc_m1);
  assign x8_last  = (x8_cnt == X8_W'(X8_DIV - 1));
  assign pre_tick = mod_tick && (!div.range_x8 || x8_last);
  assign half_nxt = div.half_rate ? (pre_tick ? ~half_q : half_q) : 1'b0;
  assign bit_stb  = pre_tick && (!div.half_rate || !half_q);
  assign bclk     = bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      mod_cnt <= '0;
      x8_cnt  <= '0;
      half_q  <= 1'b0;
      bclk_q  <= 1'b0;
    end else begin
      mod_cnt <= mod_tick ? '0 : mod_cnt + 1'b1;
      if (mod_tick)
        x8_cnt <= (div.range_x8 && !x8_last) ? x8_cnt + 1'b1 : '0;
      half_q <= half_nxt;
      bclk_q <= div.half_rate ? half_nxt : bit_stb;
    end
  end

  // R3
  half_sq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div.half_rate && !pre_tick) |=> $stable(half_q));
endmodule

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq
  import tdm_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_stb,
  input  tdm_frm_t          frm_act,
  input  tdm_frm_t          frm_in,
  output logic              frame_start,
  output logic              fs_lvl,
  output logic              word_start,
  output logic [SLOT_W-1:0] slot_idx
);
  logic     run_q;
  tdm_pos_t pos_q;
  tdm_pos_t pos_new;
  tdm_pos_t lead_pos;
  tdm_frm_t frm_nxt;
  logic     lvl_nxt;

  assign lead_pos.bit_i  = frm_act.bits_m1;
  assign lead_pos.slot_i = frm_act.slots_m1;
  assign pos_new     = run_q ? pos_step(pos_q, frm_act) : lead_pos;
  assign frame_start = bit_stb && run_q &&
                       (pos_new.bit_i == '0) && (pos_new.slot_i == '0);
  assign frm_nxt     = frame_start ? frm_in : frm_act;
  assign lvl_nxt     = frm_nxt.fs_early ? fs_hit(pos_step(pos_new, frm_nxt), frm_nxt)
                                        : fs_hit(pos_new, frm_nxt);
  assign slot_idx    = pos_q.slot_i;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      run_q      <= 1'b0;
      pos_q      <= '0;
      fs_lvl     <= 1'b0;
      word_start <= 1'b0;
    end else if (bit_stb) begin
      run_q      <= 1'b1;
      pos_q      <= pos_new;
      fs_lvl     <= lvl_nxt;
      word_start <= run_q && (pos_new.bit_i == '0);
    end else begin
      word_start <= 1'b0;
    end
  end

  // R6
  fs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bit_stb) |=> $stable(fs_lvl));
  // R4
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bit_stb) |=> $stable(slot_idx));
  // R4
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pos_q.slot_i <= frm_act.slots_m1));
endmodule

// File: rtl/tdm_clk_gen.sv
module tdm_clk_gen
  import tdm_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PSC_W-1:0]  psc_m1,
  input  logic              range_x8,
  input  logic              half_rate,
  input  logic [SLOT_W-1:0] slots_m1,
  input  logic [WLEN_W-1:0] bits_m1,
  input  logic              fs_inv,
  input  logic              fs_word,
  input  logic              fs_early,
  output logic              bclk,
  output logic              fs,
  output logic              word_start,
  output logic [SLOT_W-1:0] slot_idx
);
  tdm_cfg_t cfg_in;
  tdm_cfg_t cfg_act;
  logic     bit_stb;
  logic     frame_start;
  logic     fs_lvl;

  assign cfg_in.div.psc_m1    = psc_m1;
  assign cfg_in.div.range_x8  = range_x8;
  assign cfg_in.div.half_rate = half_rate;
  assign cfg_in.frm.slots_m1  = slots_m1;
  assign cfg_in.frm.bits_m1   = bits_m1;
  assign cfg_in.frm.fs_word   = fs_word;
  assign cfg_in.frm.fs_early  = fs_early;
  assign cfg_in.fs_inv        = fs_inv;

  tdm_cfg_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (!en || frame_start),
    .cfg_in  (cfg_in),
    .cfg_act (cfg_act)
  );

  tdm_bit_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .div     (cfg_act.div),
    .bit_stb (bit_stb),
    .bclk    (bclk)
  );

  tdm_frame_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .bit_stb     (bit_stb),
    .frm_act     (cfg_act.frm),
    .frm_in      (cfg_in.frm),
    .frame_start (frame_start),
    .fs_lvl      (fs_lvl),
    .word_start  (word_start),
    .slot_idx    (slot_idx)
  );

  assign fs = fs_lvl ^ cfg_act.fs_inv;

  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk && !word_start && (slot_idx == '0) && (fs == cfg_act.fs_inv)));
  // R4
  ws_on_bclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> bclk);
  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_start) |=> $stable(cfg_act));
endmodule

// File: tb/tdm_clk_gen_tb.sv
`timescale 1ns/1ps
module tdm_clk_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] psc_m1 = '0;
  logic       range_x8 = 1'b0, half_rate = 1'b0;
  logic [4:0] slots_m1 = '0, bits_m1 = '0;
  logic       fs_inv = 1'b0, fs_word = 1'b0, fs_early = 1'b0;
  logic       bclk, fs, word_start;
  logic [4:0] slot_idx;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tdm_clk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .psc_m1(psc_m1), .range_x8(range_x8),
    .half_rate(half_rate), .slots_m1(slots_m1), .bits_m1(bits_m1),
    .fs_inv(fs_inv), .fs_word(fs_word), .fs_early(fs_early),
    .bclk(bclk), .fs(fs), .word_start(word_start), .slot_idx(slot_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fs_model(int b, int s, int cw, int cs, bit word, bit early, bit inv);
    int nb = b;
    int ns = s;
    bit hit;
    if (early) begin
      if (b >= cw) begin nb = 0; ns = (s >= cs) ? 0 : s + 1; end
      else nb = b + 1;
    end
    hit = (ns == 0) && (word || nb == 0);
    return int'(hit ^ inv);
  endfunction

  task automatic run_case(input int p, input int rng, input int d2, input int s, input int w,
                          input int inv, input int word, input int early, input int nev,
                          input int chg_at, input int new_s);
    int cs = s;
    int ps = s;
    int b = 0;
    int sl = 0;
    int k = 0;
    int cyc = 0;
    int last = 0;
    int hi = 0;
    int per;
    bit prev = 1'b0;
    bit ev;
    string ptag, ftag;
    @(negedge clk);
    en = 1'b0;
    psc_m1 = 8'(p); range_x8 = rng[0]; half_rate = d2[0];
    slots_m1 = 5'(s); bits_m1 = 5'(w);
    fs_inv = inv[0]; fs_word = word[0]; fs_early = early[0];
    repeat (2) @(negedge clk);
    en = 1'b1;
    per  = (p + 1) * (rng != 0 ? 8 : 1) * (d2 != 0 ? 2 : 1);
    ptag = (d2 != 0) ? "R3" : (rng != 0) ? "R2" : "R1";
    ftag = (early != 0) ? "R8" : (inv != 0) ? "R9" : (word != 0) ? "R7" : "R6";
    while (k < nev) begin
      @(negedge clk);
      cyc++;
      ev = (d2 != 0) ? (bclk && !prev) : bclk;
      if (d2 != 0 && prev && !bclk) begin
        chk(hi == per / 2, "R3 high phase", hi, per / 2);
      end
      hi = bclk ? hi + 1 : 0;
      prev = bclk;
      if (ev) begin
        if (k == 0) begin
          b = w; sl = cs;
        end else begin
          if (b >= w) begin b = 0; sl = (sl >= cs) ? 0 : sl + 1; end
          else b = b + 1;
          if (b == 0 && sl == 0) cs = ps;
          chk(cyc - last == per, ptag, cyc - last, per);
        end
        last = cyc;
        chk(int'(slot_idx) == sl, (k == 0) ? "R5 slot" : "R4 slot", int'(slot_idx), sl);
        chk(int'(word_start) == int'(k > 0 && b == 0), (k == 0) ? "R5 ws" : "R4 ws",
            int'(word_start), int'(k > 0 && b == 0));
        chk(int'(fs) == fs_model(b, sl, w, cs, word[0], early[0], inv[0]), ftag,
            int'(fs), fs_model(b, sl, w, cs, word[0], early[0], inv[0]));
        if (k == chg_at) begin
          slots_m1 = 5'(new_s);
          ps = new_s;
        end
        k++;
      end
    end
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!bclk && !word_start && slot_idx == 0, "R10 idle", int'({bclk, word_start, slot_idx}), 0);
    chk(fs == inv[0], "R10 idle fs", int'(fs), inv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bclk && !fs && !word_start && slot_idx == 0, "R10 reset", int'({bclk, fs, word_start, slot_idx}), 0);
    // Directed corners
    run_case(255, 0, 0, 1, 1, 0, 0, 0, 5, -1, 0);    // R1 maximum modulus
    run_case(0, 0, 0, 31, 0, 0, 0, 0, 70, -1, 0);    // R4 32 one-bit slots
    run_case(0, 0, 1, 0, 31, 1, 1, 1, 70, -1, 0);    // R7 R8 R9 32-bit slot
    run_case(255, 1, 1, 1, 1, 0, 0, 1, 3, -1, 0);    // R2 R3 deepest division
    run_case(1, 0, 0, 3, 1, 0, 1, 0, 24, 3, 1);      // R11 slot count change mid-frame
    run_case(0, 0, 0, 2, 2, 1, 0, 0, 12, -1, 0);     // R9 inverted one-bit sync
    // Random mix
    for (int i = 0; i < 20; i++) begin
      int rng = ($urandom % 4 == 0) ? 1 : 0;
      int p   = (rng != 0) ? int'($urandom % 2) : int'($urandom % 5);
      int s   = int'($urandom % 5);
      int w   = int'($urandom % 6);
      int nev = 2 * (s + 1) * (w + 1) + 3;
      if (nev > 80) nev = 80;
      run_case(p, rng, int'($urandom % 2), s, w, int'($urandom % 2),
               int'($urandom % 2), int'($urandom % 2), nev, -1, 0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule